// File: doc/BRIEF.md
# SPI Mixed-Signal Hub Register Interface

This block is the peripheral end of a 32-pin monitoring hub that a host reaches over a four-wire serial link. The link uses clock polarity 0 and phase 0, and every transfer is a 16-bit frame. The link lines are oversampled by the block's own clock. One command byte space serves two purposes. A set "I/O select" bit addresses sixteen 8-bit configuration registers. A clear bit makes the byte an ADC channel read. ADC results arrive on a flat parallel port from outside the block, one 12-bit value per channel.

A read takes two frames with chip-select released between them. The first frame carries the command. The block shifts the reply out during the next frame and ignores whatever the host sends in that frame. A write is one frame: the command byte followed by the data byte. The block holds three 32-bit pin banks: input enable, output enable and output value. Each pin therefore works as an ADC input, a digital input or a digital output. An ADC reply carries a flag that tells the host the pin it asked for is currently muxed to digital use.

Top module: `mshub_spi_regif`

## Requirements
- R1: After reset all three pin banks are zero, so every pin is an ADC input, and MISO is 0.
- R2: A command byte with bits 7:6 = 00 and bit 5 = 0 is an ADC read of channel {bit4..bit0}. The next frame returns bit15=0, bit14=flag, bits13:12=00 and bits11:0=that channel's result.
- R3: The ADC flag (bit 14 of the reply) is 1 exactly when the channel's pin has its input-enable or output-enable bit set.
- R4: A command byte 0b0011_iiii is a register read of index iiii. The next frame returns 8'h00 in bits 15:8 and the register value in bits 7:0.
- R5: A single frame with command byte 0b0010_iiii and data byte d stores d into register iiii. Indices 4..7 are input enable, 8..11 output enable and 12..15 output value. Within each group, offset 3 holds pins 7..0, offset 2 pins 15..8, offset 1 pins 23..16 and offset 0 pins 31..24. Pin p is bit p mod 8.
- R6: Indices 0..3 report the pins' digital input levels, in the same bank order as R5. Writes to them change nothing.
- R7: A pin with its output-enable bit set is an output. Otherwise a set input-enable bit makes it an input. Its bit in indices 0..3 is the pin level when it is an input, and 0 otherwise.
- R8: A frame cut short by chip-select going high is discarded, and the next frame starts counting from bit 0.
- R9: The frame after a read command is its reply frame. Its MOSI content has no effect, and the pending reply is dropped once that frame completes.
- R10: A command byte with bits 7:6 not 00 is ignored. It stores nothing and queues no reply.
- R11: In a frame that serves no reply, MISO stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the serial link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck_i | input | 1 | Serial clock from the host, idle low |
| spi_cs_n_i | input | 1 | Active-low chip-select |
| spi_mosi_i | input | 1 | Host-to-block serial data |
| spi_miso_o | output | 1 | Block-to-host serial data |
| adc_result_i | input | NUM_PINS*ADC_W | Conversion result of channel c at bits c*ADC_W +: ADC_W |
| pin_level_i | input | NUM_PINS | Digital level of each pin |
| pin_in_en_o | output | NUM_PINS | Input-enable bank |
| pin_out_en_o | output | NUM_PINS | Output-enable bank |
| pin_out_val_o | output | NUM_PINS | Output-value bank |

## Verification
On every cycle, the assertions check four things. The pin banks move only when a frame completes. A frame with illegal top command bits leaves them untouched. A pending reply never outlives its reply frame. MISO holds still between serial clock falling edges. Three things show only in the bench's scenarios: the exact reply words, the mapping from pin to bank and bit, and the priority of output over input in the input-level registers. They are checked against hand-derived values, and the bench also drives aborted frames and reply frames that carry write-looking data.

// File: rtl/mshub_pkg.sv
package mshub_pkg;

   localparam int CMD_W = 8;

   // command byte layout; the host depends on these positions
   typedef struct packed {
      logic [1:0] zero;   // must be 00
      logic       ioset;  // 1: register space, 0: ADC channel read
      logic       rw;     // register read when set, also channel bit 4
      logic [3:0] idx;    // register index or channel bits 3:0
   } cmd_t;

   // register groups selected by idx[3:2]
   typedef enum logic [1:0] {
      GRP_LEVEL  = 2'd0,
      GRP_IN_EN  = 2'd1,
      GRP_OUT_EN = 2'd2,
      GRP_OUT_VAL = 2'd3
   } reg_grp_e;

endpackage

// File: rtl/mshub_sync.sv
module mshub_sync #(
   parameter int            W      = 1,
   parameter int            STAGES = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("mshub_sync: STAGES must be at least 1");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= RST_VAL;
            else if (s == 0) stg[s] <= d;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/mshub_spi_shifter.sv
module mshub_spi_shifter #(
   parameter  int FRAME_W = 16,
   localparam int CNT_W   = $clog2(FRAME_W)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sck_s,
   input  logic               cs_n_s,
   input  logic               mosi_s,
   input  logic [FRAME_W-1:0] tx_word,
   output logic               frame_vld,
   output logic [FRAME_W-1:0] frame_data,
   output logic               cs_act,
   output logic               cs_start,
   output logic               sck_fall,
   output logic [CNT_W-1:0]   bit_cnt,
   output logic               miso
);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W-1);

   logic               sck_q, cs_q, sck_rise;
   logic [FRAME_W-1:0] rx_sh, tx_sh;

   assign cs_act   = !cs_n_s;
   assign cs_start = cs_act && !cs_q;
   assign sck_rise = cs_act && sck_s && !sck_q;
   assign sck_fall = cs_act && !sck_s && sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b0;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_act;
      end
   end

   // receive side: sample on rising edge, drop partial frames
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sh      <= '0;
         bit_cnt    <= '0;
         frame_vld  <= 1'b0;
         frame_data <= '0;
      end else begin
         frame_vld <= 1'b0;
         if (!cs_act) begin
            rx_sh   <= '0;
            bit_cnt <= '0;
         end else if (sck_rise) begin
            rx_sh   <= {rx_sh[FRAME_W-2:0], mosi_s};
            bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
            if (bit_cnt == LAST_BIT) begin
               frame_vld  <= 1'b1;
               frame_data <= {rx_sh[FRAME_W-2:0], mosi_s};
            end
         end
      end
   end

   // transmit side: first bit valid at select, advance on falling edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        tx_sh <= '0;
      else if (cs_start) tx_sh <= tx_word;
      else if (sck_fall) tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
   end

   assign miso = cs_act && tx_sh[FRAME_W-1];
endmodule

// File: rtl/mshub_pin_regs.sv
module mshub_pin_regs
   import mshub_pkg::*;
#(
   parameter  int NUM_PINS  = 32,
   parameter  int BANK_W    = 8,
   localparam int NUM_BANKS = NUM_PINS / BANK_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_idx,
   input  logic [BANK_W-1:0]   wr_data,
   input  logic [3:0]          rd_idx,
   input  logic [NUM_PINS-1:0] pin_level_s,
   output logic [BANK_W-1:0]   rd_data,
   output logic [NUM_PINS-1:0] in_en,
   output logic [NUM_PINS-1:0] out_en,
   output logic [NUM_PINS-1:0] out_val
);
   logic [NUM_PINS-1:0] level_vis;

   generate
      if (NUM_BANKS != 4 || NUM_PINS % BANK_W != 0) begin : g_bad
         $error("mshub_pin_regs: index field needs exactly four banks per group");
      end
      // bank b (pins b*BANK_W..) sits at group offset NUM_BANKS-1-b
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         localparam logic [1:0] SUB = 2'(NUM_BANKS - 1 - b);
         logic hit;
         assign hit = wr_en && (wr_idx[1:0] == SUB);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               in_en  [b*BANK_W +: BANK_W] <= '0;
               out_en [b*BANK_W +: BANK_W] <= '0;
               out_val[b*BANK_W +: BANK_W] <= '0;
            end else if (hit) begin
               case (reg_grp_e'(wr_idx[3:2]))
                  GRP_IN_EN:   in_en  [b*BANK_W +: BANK_W] <= wr_data;
                  GRP_OUT_EN:  out_en [b*BANK_W +: BANK_W] <= wr_data;
                  GRP_OUT_VAL: out_val[b*BANK_W +: BANK_W] <= wr_data;
                  default: ;   // level group is read-only
               endcase
            end
         end
      end
   endgenerate

   // output enable wins over input enable
   assign level_vis = pin_level_s & in_en & ~out_en;

   always_comb begin
      int bank;
      bank = NUM_BANKS - 1 - int'(rd_idx[1:0]);
      case (reg_grp_e'(rd_idx[3:2]))
         GRP_LEVEL:  rd_data = level_vis[bank*BANK_W +: BANK_W];
         GRP_IN_EN:  rd_data = in_en    [bank*BANK_W +: BANK_W];
         GRP_OUT_EN: rd_data = out_en   [bank*BANK_W +: BANK_W];
         default:    rd_data = out_val  [bank*BANK_W +: BANK_W];
      endcase
   end
endmodule

// File: rtl/mshub_spi_regif.sv
module mshub_spi_regif
   import mshub_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADC_W       = 12,
   parameter int BANK_W      = 8,
   parameter int FRAME_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      spi_sck_i,
   input  logic                      spi_cs_n_i,
   input  logic                      spi_mosi_i,
   output logic                      spi_miso_o,
   input  logic [NUM_PINS*ADC_W-1:0] adc_result_i,
   input  logic [NUM_PINS-1:0]       pin_level_i,
   output logic [NUM_PINS-1:0]       pin_in_en_o,
   output logic [NUM_PINS-1:0]       pin_out_en_o,
   output logic [NUM_PINS-1:0]       pin_out_val_o
);
   localparam int CNT_W  = $clog2(FRAME_W);
   localparam int PAD_W  = FRAME_W - 2 - ADC_W;
   localparam int SYNC_W = NUM_PINS + 3;
   localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b1, 1'b0, {NUM_PINS{1'b0}}};

   generate
      if (FRAME_W != 2*CMD_W || PAD_W < 0 || NUM_PINS != 32) begin : g_bad
         $error("mshub_spi_regif: frame must be 16 bits, 32 pins, ADC_W <= 14");
      end
   endgenerate

   logic                sck_s, cs_n_s, mosi_s;
   logic [NUM_PINS-1:0] level_s;
   logic                frame_vld, cs_act, cs_start, sck_fall;
   logic [FRAME_W-1:0]  frame_data, tx_word, pend_word, adc_word, reg_word;
   logic [CNT_W-1:0]    bit_cnt;
   logic                pend_vld, cmd_legal, wr_en, flag;
   logic [BANK_W-1:0]   rd_data;
   logic [4:0]          chan;
   logic [ADC_W-1:0]    adc_sel;
   cmd_t                cmd;

   mshub_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   ({spi_sck_i, spi_cs_n_i, spi_mosi_i, pin_level_i}),
      .q   ({sck_s, cs_n_s, mosi_s, level_s})
   );

   mshub_spi_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .sck_s      (sck_s),
      .cs_n_s     (cs_n_s),
      .mosi_s     (mosi_s),
      .tx_word    (tx_word),
      .frame_vld  (frame_vld),
      .frame_data (frame_data),
      .cs_act     (cs_act),
      .cs_start   (cs_start),
      .sck_fall   (sck_fall),
      .bit_cnt    (bit_cnt),
      .miso       (spi_miso_o)
   );

   assign cmd       = cmd_t'(frame_data[FRAME_W-1 -: CMD_W]);
   assign cmd_legal = (cmd.zero == 2'b00);
   assign wr_en     = frame_vld && !pend_vld && cmd_legal && cmd.ioset && !cmd.rw;
   assign chan      = {cmd.rw, cmd.idx};

   mshub_pin_regs #(.NUM_PINS(NUM_PINS), .BANK_W(BANK_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_idx      (cmd.idx),
      .wr_data     (frame_data[BANK_W-1:0]),
      .rd_idx      (cmd.idx),
      .pin_level_s (level_s),
      .rd_data     (rd_data),
      .in_en       (pin_in_en_o),
      .out_en      (pin_out_en_o),
      .out_val     (pin_out_val_o)
   );

   assign adc_sel  = adc_result_i[int'(chan)*ADC_W +: ADC_W];
   assign flag     = pin_in_en_o[chan] || pin_out_en_o[chan];
   assign adc_word = {1'b0, flag, {PAD_W{1'b0}}, adc_sel};
   assign reg_word = {{(FRAME_W-BANK_W){1'b0}}, rd_data};

   // one reply slot: filled by a read command, consumed by the next frame
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_word <= '0;
      end else if (frame_vld) begin
         if (pend_vld) begin
            pend_vld <= 1'b0;
         end else if (cmd_legal && (!cmd.ioset || cmd.rw)) begin
            pend_vld  <= 1'b1;
            pend_word <= cmd.ioset ? reg_word : adc_word;
         end
      end
   end

   assign tx_word = pend_vld ? pend_word : '0;
endmodule

// File: rtl/mshub_spi_regif_chk.sv
module mshub_spi_regif_chk #(
   parameter int NUM_PINS = 32,
   parameter int FRAME_W  = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cs_act,
   input logic                cs_start,
   input logic                sck_fall,
   input logic                spi_miso_o,
   input logic                frame_vld,
   input logic [FRAME_W-1:0]  frame_data,
   input logic                pend_vld,
   input logic [NUM_PINS-1:0] pin_in_en_o,
   input logic [NUM_PINS-1:0] pin_out_en_o,
   input logic [NUM_PINS-1:0] pin_out_val_o
);
   AST_BANKS_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_vld |=> ($stable(pin_in_en_o) && $stable(pin_out_en_o) && $stable(pin_out_val_o))); // R5

   AST_ILLEGAL_CMD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && frame_data[FRAME_W-1 -: 2] != 2'b00) |=>
      ($stable(pin_in_en_o) && $stable(pin_out_en_o) && $stable(pin_out_val_o))); // R10

   AST_REPLY_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_vld && pend_vld) |=> !pend_vld); // R9

   AST_MISO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && !sck_fall && !cs_start) |=> (!cs_act || $stable(spi_miso_o))); // R2

   AST_FRAME_UNDER_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      frame_vld |-> $past(cs_act)); // R8
endmodule

bind mshub_spi_regif mshub_spi_regif_chk #(.NUM_PINS(NUM_PINS), .FRAME_W(FRAME_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cs_act        (cs_act),
   .cs_start      (cs_start),
   .sck_fall      (sck_fall),
   .spi_miso_o    (spi_miso_o),
   .frame_vld     (frame_vld),
   .frame_data    (frame_data),
   .pend_vld      (pend_vld),
   .pin_in_en_o   (pin_in_en_o),
   .pin_out_en_o  (pin_out_en_o),
   .pin_out_val_o (pin_out_val_o)
);

// File: tb/mshub_spi_regif_tb.sv
module mshub_spi_regif_tb;
   localparam int NP = 32;
   localparam int AW = 12;
   localparam int HP = 6;   // serial half period in clk cycles

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic          miso;
   logic [NP*AW-1:0] adc;
   logic [NP-1:0] level = 32'hC3A5_965A;
   logic [NP-1:0] in_en, out_en, out_val;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   mshub_spi_regif u_dut (
      .clk (clk), .rst_n (rst_n),
      .spi_sck_i (sck), .spi_cs_n_i (cs_n), .spi_mosi_i (mosi), .spi_miso_o (miso),
      .adc_result_i (adc), .pin_level_i (level),
      .pin_in_en_o (in_en), .pin_out_en_o (out_en), .pin_out_val_o (out_val)
   );

   // ADC stub: channel 31 full scale, others 0xA00 + channel
   initial begin
      for (int c = 0; c < NP; c++)
         adc[c*AW +: AW] = (c == 31) ? 12'hFFF : 12'hA00 + 12'(c);
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
      rx = '0;
      @(negedge clk) cs_n = 1'b0;
      repeat (8) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         mosi = tx[15-i];
         repeat (HP) @(negedge clk);
         rx[15-i] = miso;
         sck = 1'b1;
         repeat (HP) @(negedge clk);
         sck = 1'b0;
      end
      repeat (HP) @(negedge clk);
      cs_n = 1'b1;
      mosi = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic rd(input logic [7:0] c, output logic [15:0] rep);
      logic [15:0] dummy;
      xfer({c, 8'h00}, 16, dummy);
      xfer(16'h0000, 16, rep);
   endtask

   // {req, kind (1 read / 0 write), cmd, data, expected reply or write-frame MISO}
   localparam int NV = 20;
   localparam logic [39:0] VEC [NV] = '{
      {4'd2,  4'd1, 8'h03, 8'h00, 16'h0A03},  // R2 ADC ch3, no flag
      {4'd1,  4'd1, 8'h34, 8'h00, 16'h0000},  // R1 in-enable reset 0
      {4'd11, 4'd0, 8'h27, 8'h0F, 16'h0000},  // R11 write, pins 0..3 inputs
      {4'd4,  4'd1, 8'h37, 8'h00, 16'h000F},  // R4 readback
      {4'd3,  4'd1, 8'h02, 8'h00, 16'h4A02},  // R3 flag on input pin
      {4'd3,  4'd1, 8'h04, 8'h00, 16'h0A04},  // R3 no flag pin 4
      {4'd7,  4'd1, 8'h33, 8'h00, 16'h000A},  // R7 level 5A & 0F
      {4'd5,  4'd0, 8'h28, 8'h80, 16'h0000},  // R5 pin 31 output
      {4'd3,  4'd1, 8'h1F, 8'h00, 16'h4FFF},  // R3 ch31 output flag
      {4'd5,  4'd0, 8'h2C, 8'hA5, 16'h0000},  // R5 out values 31..24
      {4'd5,  4'd1, 8'h3C, 8'h00, 16'h00A5},  // R5
      {4'd6,  4'd0, 8'h20, 8'hFF, 16'h0000},  // R6 write to read-only
      {4'd5,  4'd0, 8'h24, 8'hFF, 16'h0000},  // R5 in-enable 31..24
      {4'd7,  4'd1, 8'h30, 8'h00, 16'h0043},  // R7 C3 with pin 31 masked
      {4'd4,  4'd1, 8'h34, 8'h00, 16'h00FF},  // R4
      {4'd5,  4'd0, 8'h25, 8'h01, 16'h0000},  // R5 pin 16 input
      {4'd3,  4'd1, 8'h10, 8'h00, 16'h4A10},  // R3
      {4'd2,  4'd1, 8'h11, 8'h00, 16'h0A11},  // R2
      {4'd7,  4'd1, 8'h31, 8'h00, 16'h0001},  // R7 A5 & 01
      {4'd4,  4'd1, 8'h38, 8'h00, 16'h0080}   // R4
   };

   initial begin
      logic [15:0] rep;
      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check("R1 banks", {in_en | out_en | out_val}, 32'h0);
      check("R1 miso", {31'b0, miso}, 32'h0);

      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = $sformatf("R%0d row %0d", VEC[v][39:36], v);
         if (VEC[v][35:32] == 4'd1) rd(VEC[v][31:24], rep);
         else xfer(VEC[v][31:16], 16, rep);
         check(tag, {16'h0, rep}, {16'h0, VEC[v][15:0]});
      end

      // R5 pin mapping at the ports
      check("R5 in_en",   in_en,   32'hFF01_000F);
      check("R5 out_en",  out_en,  32'h8000_0000);
      check("R5 out_val", out_val, 32'hA500_0000);

      // R10 illegal top bits look like a write of index 7
      xfer(16'hE7FF, 16, rep);
      rd(8'h37, rep);
      check("R10 ignored", {16'h0, rep}, 32'h000F);

      // R8 aborted write, then a clean read
      xfer(16'h2700, 12, rep);
      rd(8'h37, rep);
      check("R8 partial dropped", {16'h0, rep}, 32'h000F);

      // R9 reply frame carrying a write pattern
      xfer(16'h3700, 16, rep);
      xfer(16'h2700, 16, rep);
      check("R9 reply", {16'h0, rep}, 32'h000F);
      check("R9 in_en kept", in_en, 32'hFF01_000F);
      xfer(16'h2D00, 16, rep);
      check("R11 no stale reply", {16'h0, rep}, 32'h0);

      // R7 level change reaches the input registers
      level[7:0] = 8'hFF;
      repeat (4) @(negedge clk);
      rd(8'h33, rep);
      check("R7 new level", {16'h0, rep}, 32'h000F);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule